// File: doc/BRIEF.md
# Background Register Parity Checker

This block runs next to a multi-threaded register array and watches the same write traffic: the write strobe, the register index, the data word and the parity bit supplied with it. It keeps its own copy of every register word and stored parity bit for every thread. For each register of the currently active thread it rebuilds the XOR of the data word over a fixed number of cycles. Once that rebuild is finished, it compares the result with the stored bit on every clock until the register is written again. Nothing depends on a read of the register.

A read-style port takes a register index and returns that register's error flag, decoded the same way a data read port would decode it. A sticky summary flag records that any register has shown an error, so a fault can be seen before the faulty register is ever read. The flag stays set until a clear input is pulsed. A change of the thread select restarts the rebuild for every register against the newly active thread's contents. A fault-injection strobe flips one stored parity bit without a write, so the detection path can be exercised.

Top module: `rfpar_checker`

## Requirements
- R1: After reset all shadow words and stored parity bits are zero, no register is in flight, `rd_err` is 0 and `err_sticky` is 0.
- R2: Even parity is used. A register is correct when its stored bit equals the XOR of all its data bits. A write that follows this rule never raises `rd_err` for that register.
- R3: A write samples at edge k. The written register's flag is masked to 0 after edges k, k+1 and k+2, and it reflects the comparison from edge k+3 onward, where LATENCY is 3.
- R4: A write to a register whose rebuild is still in flight restarts its countdown with the new word. The flag then stays masked for LATENCY cycles after the second write.
- R5: Comparison is continuous. When a settled register's stored bit is flipped at edge j, `rd_err` for that register is 1 after edge j, with no read and no write.
- R6: `err_sticky` is set at the edge after any settled register mismatches and holds until `err_clr` is sampled high. A clear wins over a set at the same edge.
- R7: A write goes to the storage of the thread named by `thread_sel` at that edge. When `thread_sel` differs from the active thread at an edge, that thread becomes active and every register is masked for LATENCY cycles. The register is then judged on that thread's stored word and bit.
- R8: `rd_err` shows only the flag of the register chosen by `rd_idx`. An error in one register does not appear at another index.
- R9: `inj_en` flips the stored parity bit of register `inj_idx` in the active thread without restarting its rebuild. If a write to the same register and thread happens at the same edge, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thread_sel | input | TID_W | Thread select; a change restarts all checks |
| wr_en | input | 1 | Write strobe seen by the array |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | DATA_W | Data word being written |
| wr_par | input | 1 | Parity bit written with the word |
| inj_en | input | 1 | Flip one stored parity bit of the active thread |
| inj_idx | input | IDX_W | Register whose stored bit is flipped |
| rd_idx | input | IDX_W | Register index for the error read port |
| rd_err | output | 1 | Error flag of register `rd_idx` |
| err_clr | input | 1 | Clears the sticky flag |
| err_sticky | output | 1 | Sticky any-register error flag |

## Verification
A lane whose countdown is off shows `rd_err` one cycle early or late after a write or a thread switch, and the bench sees that on the first affected cycle. A wrong shadow word or a stored bit sent to the wrong thread shows up as a flag that is wrong in polarity. This is visible as soon as the register settles and it is read, or one cycle later through `err_sticky` for any index. A reference model of words, bits and countdowns is compared with both outputs on every clock. This covers directed latency windows, in-flight rewrites, injections, thread switches and a random run.

// File: rtl/rfpar_pkg.sv
package rfpar_pkg;

    // Lane action per clock.
    typedef enum logic [1:0] {
        LN_HOLD    = 2'd0,
        LN_RESTART = 2'd1,
        LN_STEP    = 2'd2
    } lane_op_e;

    // Sticky flag action per clock.
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_SET   = 2'd1,
        ST_CLEAR = 2'd2
    } sticky_op_e;

    // Bits folded per cycle so that LATENCY steps cover the word.
    function automatic int unsigned chunk_width(input int unsigned dw, input int unsigned lat);
        return (dw + lat - 1) / lat;
    endfunction

endpackage

// File: rtl/rfpar_shadow.sv
module rfpar_shadow #(
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned NUM_THREADS = 2,
    localparam int unsigned IDX_W = $clog2(NUM_REGS),
    localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [TID_W-1:0]                   wr_thread,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               wr_par,
    input  logic                               inj_en,
    input  logic [TID_W-1:0]                   inj_thread,
    input  logic [IDX_W-1:0]                   inj_idx,
    input  logic [TID_W-1:0]                   act_thread,
    output logic [NUM_REGS-1:0][DATA_W-1:0]    act_data,
    output logic [NUM_REGS-1:0]                act_par
);

    logic [DATA_W-1:0] word_q [NUM_THREADS][NUM_REGS];
    logic [NUM_REGS-1:0] pbit_q [NUM_THREADS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                pbit_q[t] <= '0;
                for (int r = 0; r < NUM_REGS; r++) begin
                    word_q[t][r] <= '0;
                end
            end
        end else begin
            // Injection first; a write to the same slot overrides it.
            if (inj_en) begin
                pbit_q[inj_thread][inj_idx] <= ~pbit_q[inj_thread][inj_idx];
            end
            if (wr_en) begin
                word_q[wr_thread][wr_idx] <= wr_data;
                pbit_q[wr_thread][wr_idx] <= wr_par;
            end
        end
    end

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_view
            assign act_data[r] = word_q[act_thread][r];
            assign act_par[r]  = pbit_q[act_thread][r];
        end
    endgenerate

endmodule

// File: rtl/rfpar_lane.sv
module rfpar_lane
    import rfpar_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned LATENCY = 3,
    localparam int unsigned CHUNK_W = chunk_width(DATA_W, LATENCY),
    localparam int unsigned CNT_W   = $clog2(LATENCY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [DATA_W-1:0] data,
    input  logic              stored_par,
    output logic              settled,
    output logic              mismatch
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic             acc;
    } lane_state_t;

    lane_state_t st_q;
    lane_op_e    op;
    int          step_idx;

    function automatic logic chunk_xor(input logic [DATA_W-1:0] d, input int step);
        logic p;
        p = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if ((i / CHUNK_W) == step) p ^= d[i];
        end
        return p;
    endfunction

    always_comb begin
        if (restart)                op = LN_RESTART;
        else if (st_q.left != '0)   op = LN_STEP;
        else                        op = LN_HOLD;
        step_idx = LATENCY - int'(st_q.left);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            case (op)
                LN_RESTART: begin
                    st_q.left <= CNT_W'(LATENCY);
                    st_q.acc  <= 1'b0;
                end
                LN_STEP: begin
                    st_q.left <= st_q.left - 1'b1;
                    st_q.acc  <= st_q.acc ^ chunk_xor(data, step_idx);
                end
                default: st_q <= st_q;
            endcase
        end
    end

    assign settled  = (st_q.left == '0);
    assign mismatch = settled && (st_q.acc != stored_par);

endmodule

// File: rtl/rfpar_status.sv
module rfpar_status
    import rfpar_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] err_vec,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                err_clr,
    output logic                rd_err,
    output logic                err_sticky
);

    sticky_op_e sop;
    logic       sticky_q;

    always_comb begin
        if (err_clr)       sop = ST_CLEAR;
        else if (|err_vec) sop = ST_SET;
        else               sop = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else begin
            case (sop)
                ST_CLEAR: sticky_q <= 1'b0;
                ST_SET:   sticky_q <= 1'b1;
                default:  sticky_q <= sticky_q;
            endcase
        end
    end

    assign rd_err     = err_vec[rd_idx];
    assign err_sticky = sticky_q;

endmodule

// File: rtl/rfpar_checker.sv
module rfpar_checker
    import rfpar_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned NUM_THREADS = 2,
    parameter int unsigned LATENCY     = 3,
    localparam int unsigned IDX_W = $clog2(NUM_REGS),
    localparam int unsigned TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TID_W-1:0]  thread_sel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_err,
    input  logic              err_clr,
    output logic              err_sticky
);

    logic [TID_W-1:0]               thread_q;
    logic                           thread_chg;
    logic [NUM_REGS-1:0][DATA_W-1:0] act_data;
    logic [NUM_REGS-1:0]            act_par;
    logic [NUM_REGS-1:0]            restart;
    logic [NUM_REGS-1:0]            settled;
    logic [NUM_REGS-1:0]            err_vec;

    assign thread_chg = (thread_sel != thread_q);

    always_ff @(posedge clk) begin
        if (rst) thread_q <= '0;
        else     thread_q <= thread_sel;
    end

    rfpar_shadow #(
        .NUM_REGS   (NUM_REGS),
        .DATA_W     (DATA_W),
        .NUM_THREADS(NUM_THREADS)
    ) shadow_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_thread (thread_sel),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_par    (wr_par),
        .inj_en    (inj_en),
        .inj_thread(thread_q),
        .inj_idx   (inj_idx),
        .act_thread(thread_q),
        .act_data  (act_data),
        .act_par   (act_par)
    );

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_lane
            assign restart[r] = thread_chg || (wr_en && (wr_idx == IDX_W'(r)));

            rfpar_lane #(
                .DATA_W (DATA_W),
                .LATENCY(LATENCY)
            ) lane_i (
                .clk       (clk),
                .rst       (rst),
                .restart   (restart[r]),
                .data      (act_data[r]),
                .stored_par(act_par[r]),
                .settled   (settled[r]),
                .mismatch  (err_vec[r])
            );
        end
    endgenerate

    rfpar_status #(
        .NUM_REGS(NUM_REGS)
    ) status_i (
        .clk       (clk),
        .rst       (rst),
        .err_vec   (err_vec),
        .rd_idx    (rd_idx),
        .err_clr   (err_clr),
        .rd_err    (rd_err),
        .err_sticky(err_sticky)
    );

endmodule

// File: rtl/rfpar_checker_sva.sv
module rfpar_checker_sva #(
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_idx,
    input logic                thread_chg,
    input logic [NUM_REGS-1:0] settled,
    input logic [NUM_REGS-1:0] err_vec,
    input logic [IDX_W-1:0]    rd_idx,
    input logic                rd_err,
    input logic                err_clr,
    input logic                err_sticky
);

    // R3 / R4: a write masks the written register at the next cycle.
    p_write_masks_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !settled[$past(wr_idx)]);

    // R7: a thread switch puts every register back in flight.
    p_thread_restart_r7: assert property (@(posedge clk) disable iff (rst)
        thread_chg |=> (settled == '0));

    // R3: a flag is only raised by a settled register.
    p_flag_needs_settle_r3: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> settled[rd_idx]);

    // R6: any mismatch sets the sticky flag unless cleared.
    p_sticky_set_r6: assert property (@(posedge clk) disable iff (rst)
        ((|err_vec) && !err_clr) |=> err_sticky);

    // R6: clear takes effect at the next cycle.
    p_sticky_clear_r6: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> !err_sticky);

    // R6: the sticky flag holds without a clear.
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (err_sticky && !err_clr) |=> err_sticky);

endmodule

bind rfpar_checker rfpar_checker_sva #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .thread_chg(thread_chg),
    .settled   (settled),
    .err_vec   (err_vec),
    .rd_idx    (rd_idx),
    .rd_err    (rd_err),
    .err_clr   (err_clr),
    .err_sticky(err_sticky)
);

// File: tb/rfpar_checker_tb_top.sv
module rfpar_checker_tb_top;

    localparam int NREG = 16;
    localparam int DW   = 64;
    localparam int NTH  = 2;
    localparam int LAT  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [0:0]    thread_sel = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_par = 1'b0;
    logic          inj_en = 1'b0;
    logic [3:0]    inj_idx = '0;
    logic [3:0]    rd_idx = '0;
    logic          rd_err;
    logic          err_clr = 1'b0;
    logic          err_sticky;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1 reset";
    bit    done   = 1'b0;

    always #5 clk = ~clk;

    rfpar_checker #(.NUM_REGS(NREG), .DATA_W(DW), .NUM_THREADS(NTH), .LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .thread_sel(thread_sel), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_par(wr_par), .inj_en(inj_en), .inj_idx(inj_idx),
        .rd_idx(rd_idx), .rd_err(rd_err), .err_clr(err_clr), .err_sticky(err_sticky)
    );

    // Behavioural reference model.
    logic [DW-1:0] m_word [NTH][NREG];
    logic          m_pbit [NTH][NREG];
    int            m_left [NREG];
    int            m_thr;
    logic          m_sticky;

    function automatic logic m_flag(input int r);
        return (m_left[r] == 0) && ((^m_word[m_thr][r]) != m_pbit[m_thr][r]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTH; t++)
                for (int r = 0; r < NREG; r++) begin
                    m_word[t][r] = '0;
                    m_pbit[t][r] = 1'b0;
                end
            for (int r = 0; r < NREG; r++) m_left[r] = 0;
            m_thr = 0;
            m_sticky = 1'b0;
        end else begin
            logic any;
            any = 1'b0;
            for (int r = 0; r < NREG; r++) if (m_flag(r)) any = 1'b1;
            if (err_clr) m_sticky = 1'b0;
            else if (any) m_sticky = 1'b1;
            if (inj_en) m_pbit[m_thr][inj_idx] = ~m_pbit[m_thr][inj_idx];
            if (int'(thread_sel) != m_thr) begin
                for (int r = 0; r < NREG; r++) m_left[r] = LAT;
                m_thr = int'(thread_sel);
            end else begin
                for (int r = 0; r < NREG; r++) if (m_left[r] > 0) m_left[r]--;
            end
            if (wr_en) begin
                m_word[int'(thread_sel)][wr_idx] = wr_data;
                m_pbit[int'(thread_sel)][wr_idx] = wr_par;
                m_left[wr_idx] = LAT;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the edge.
    always @(posedge clk) begin
        #3;
        if (!rst && !done) begin
            chk({phase, " rd_err"}, rd_err, m_flag(int'(rd_idx)));
            chk({phase, " err_sticky"}, err_sticky, m_sticky);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input int idx, input logic [DW-1:0] d, input logic p);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d; wr_par = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_inj(input int idx);
        @(negedge clk);
        inj_en = 1'b1; inj_idx = 4'(idx);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic do_clear;
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    // After a sampled restart edge k (called at the negedge that follows):
    // flag 0 after k, k+1, k+2 and `fin` after k+3.
    task automatic latency_window(input string tag, input logic fin);
        #1 chk({tag, " masked k"}, rd_err, 1'b0);
        for (int i = 0; i < LAT - 1; i++) begin
            @(posedge clk); #3 chk({tag, " masked"}, rd_err, 1'b0);
        end
        @(posedge clk); #3 chk({tag, " settled"}, rd_err, fin);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        phase = "R1 reset";
        #1 chk("R1 rd_err after reset", rd_err, 1'b0);
        chk("R1 err_sticky after reset", err_sticky, 1'b0);
        idle(3);

        phase = "R2 good parity";
        w = 64'h0123_4567_89ab_cdef;
        rd_idx = 4'd2;
        do_write(2, w, ^w);
        latency_window("R2 good write", 1'b0);
        idle(3);

        phase = "R3 latency";
        w = 64'h8000_0000_0000_0001 ^ 64'h0000_0010_0000_0000;
        rd_idx = 4'd3;
        do_write(3, w, ~(^w));
        latency_window("R3 bad write", 1'b1);
        @(posedge clk); #3 chk("R6 sticky set after error", err_sticky, 1'b1);
        idle(2);

        phase = "R8 read decode";
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk); rd_idx = 4'(r);
            #1 chk("R8 per-index flag", rd_err, (r == 3) ? 1'b1 : 1'b0);
        end

        phase = "R6 clear";
        do_write(3, w, ^w);
        idle(LAT + 1);
        do_clear();
        #1 chk("R6 sticky cleared", err_sticky, 1'b0);
        idle(2);

        phase = "R4 rewrite in flight";
        rd_idx = 4'd5;
        do_write(5, 64'h1, 1'b0);
        do_write(5, 64'h3, 1'b1);
        latency_window("R4 restarted countdown", 1'b1);
        do_write(5, 64'h3, 1'b0);
        idle(LAT + 1);
        do_clear();

        phase = "R5 R9 injection";
        rd_idx = 4'd2;
        do_inj(2);
        #1 chk("R5 error after flip without write", rd_err, 1'b1);
        @(posedge clk); #3 chk("R6 sticky after injected error", err_sticky, 1'b1);
        do_inj(2);
        #1 chk("R9 second flip restores", rd_err, 1'b0);
        @(negedge clk);
        inj_en = 1'b1; inj_idx = 4'd2;
        wr_en = 1'b1; wr_idx = 4'd2; wr_data = 64'h7; wr_par = 1'b1;
        @(negedge clk);
        inj_en = 1'b0; wr_en = 1'b0;
        latency_window("R9 write wins over flip", 1'b0);
        do_clear();

        phase = "R7 thread switch";
        rd_idx = 4'd4;
        do_write(4, 64'hf0, 1'b0);
        idle(LAT + 1);
        @(negedge clk); thread_sel = 1'b1;
        @(negedge clk);
        latency_window("R7 switch to thread 1", 1'b0);
        do_write(4, 64'h1, 1'b0);
        latency_window("R7 bad word in thread 1", 1'b1);
        @(negedge clk); thread_sel = 1'b0;
        @(negedge clk);
        latency_window("R7 back to thread 0 good word", 1'b0);
        @(negedge clk); thread_sel = 1'b1;
        @(negedge clk);
        latency_window("R7 thread 1 error returns", 1'b1);
        do_write(4, 64'h1, 1'b1);
        idle(LAT + 1);
        do_clear();

        phase = "R2 R7 R9 random";
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_idx  = 4'($urandom_range(0, NREG - 1));
            wr_data = {$urandom, $urandom};
            wr_par  = ^wr_data ^ ($urandom_range(0, 7) == 0);
            inj_en  = ($urandom_range(0, 15) == 0);
            inj_idx = 4'($urandom_range(0, NREG - 1));
            err_clr = ($urandom_range(0, 19) == 0);
            rd_idx  = 4'($urandom_range(0, NREG - 1));
            if ($urandom_range(0, 29) == 0) thread_sel = ~thread_sel;
        end
        @(negedge clk);
        wr_en = 1'b0; inj_en = 1'b0; err_clr = 1'b0;
        idle(5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule